// File: doc/BRIEF.md
# Fast Page Mode DRAM Access Controller

The controller turns single-word requests from a synchronous valid/ready port into row and column strobe sequences for an asynchronous 32-bit DRAM array. The array takes its 22-bit word address in two halves over shared address pins. The upper half selects the row and is captured when the row strobes fall. The lower half selects the column and is captured when the column strobes fall. Each 16-bit half of the word has its own row strobe, and each byte lane has its own column strobe.

After a row opens, it stays open. Later requests to the same row skip activation and run as short column-only cycles. The row closes for any of three reasons: a request to another row, the row-open timer nearing its limit, or a refresh grant from an outside refresh block. After closing, the controller waits out the precharge time. Every delay is a whole number of clock cycles set by a parameter. The defaults assume a 100 MHz clock.

Writes are always early writes. The shared data pins mean the array must never drive the bus during a write. Write enable and write data are therefore set up a full cycle before any column strobe falls.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held, both row strobes, all column strobes and write enable are high, the data output enable is low, and req_ready and rd_valid are low.
- R2: req_addr[21:11] is on dram_addr when the row strobes fall. Row strobes are low at least T_RCD+1 cycles before any column strobe falls.
- R3: req_addr[10:0] is on dram_addr[10:0] when the column strobes fall.
- R4: A write lowers write enable and drives req_wdata with the output enable set at least one cycle before its column strobes fall. req_be[i] set lowers dram_cas_n[i], which gates data bits 8i+7:8i. A clear bit leaves that lane's stored byte unchanged.
- R5: A read lowers all four column strobes with the output enable low. rd_valid pulses for exactly one cycle, T_CAS+2 cycles after the accepting clock edge, carrying the addressed word.
- R6: A request whose row equals the open row is served without the row strobes rising again.
- R7: A request to another row raises the row strobes, keeps them high at least T_RP cycles, then activates the new row.
- R8: Row strobes stay low at least T_RAS_MIN cycles each time they fall.
- R9: Row strobes never stay low longer than T_RAS_MAX cycles. An idle open row is closed on its own.
- R10: While ref_grant is high, an open row is closed (subject to R8), and no new row is activated or request accepted. ref_idle is high once the row strobes are high and precharge is done.
- R11: Each column strobe stays low at least T_CAS cycles and high at least T_CP cycles between page-mode accesses.
- R12: A column strobe is low only while both row strobes are low, and the two row strobes always switch together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 22 | Word address, row in upper 11 bits |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 32 | Read data |
| ref_grant | input | 1 | Refresh block owns the array |
| ref_idle | output | 1 | Row closed and precharged |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 2 | Row strobes, lower and upper half-word |
| dram_cas_n | output | 4 | Column strobes, one per byte lane |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 32 | Data driven toward the array |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | 32 | Data returned by the array |

## Verification
The timing checks assume the parameters are consistent. T_RAS_MAX must leave room for at least one full column access beyond T_RAS_MIN, and the column field must not be wider than the row field. On the request side they assume req_addr, req_we, req_wdata and req_be stay steady while req_valid is high and until acceptance, and that ref_grant stays high until ref_idle is seen. The stimulus drives all inputs on the falling clock edge and keeps one request outstanding at a time. It lowers req_valid only after acceptance and releases the grant only after ref_idle has been sampled. It also shortens T_RAS_MAX so that an idle row expires within the run.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 11,
  parameter int DQ_W      = 32,
  parameter int T_RP      = 4,
  parameter int T_RCD     = 2,
  parameter int T_RAS_MIN = 6,
  parameter int T_RAS_MAX = 10000,
  parameter int T_CAS     = 3,
  parameter int T_CP      = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic                     req_we,
  input  logic [DQ_W-1:0]          req_wdata,
  input  logic [DQ_W/8-1:0]        req_be,
  output logic                     rd_valid,
  output logic [DQ_W-1:0]          rd_data,
  input  logic                     ref_grant,
  output logic                     ref_idle,
  output logic [ROW_W-1:0]         dram_addr,
  output logic [1:0]               dram_ras_n,
  output logic [DQ_W/8-1:0]        dram_cas_n,
  output logic                     dram_we_n,
  output logic [DQ_W-1:0]          dram_dq_out,
  output logic                     dram_dq_oe,
  input  logic [DQ_W-1:0]          dram_dq_in
);
  localparam int NL      = DQ_W / 8;
  localparam int AW      = ROW_W + COL_W;
  localparam int ACC_LIM = T_RAS_MAX - T_CAS - T_CP - 3;
  localparam int CW      = $clog2(T_RP + T_RCD + T_CAS + T_CP + 2);
  localparam int RW      = $clog2(T_RAS_MAX + 2);

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_ACT, S_OPEN, S_COL, S_CAS, S_CPRE, S_PRE
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [RW-1:0]    rcnt;
  logic [ROW_W-1:0] open_row;
  logic             ras_q;
  logic             wr_q;
  logic [NL-1:0]    lane_q;

  logic row_hit, min_ok, expire, close_row, acc;

  assign row_hit   = req_addr[AW-1:COL_W] == open_row;
  assign min_ok    = rcnt >= RW'(T_RAS_MIN - 1);
  assign expire    = rcnt >= RW'(ACC_LIM);
  assign close_row = ((req_valid && !row_hit) || ref_grant || expire) && min_ok;
  assign req_ready = (st == S_OPEN) && row_hit && !ref_grant && !expire;
  assign acc       = req_valid && req_ready;
  assign ref_idle  = (st == S_IDLE);
  assign dram_ras_n = {2{ras_q}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      rcnt        <= '0;
      open_row    <= '0;
      ras_q       <= 1'b1;
      wr_q        <= 1'b0;
      lane_q      <= '0;
      dram_addr   <= '0;
      dram_cas_n  <= '1;
      dram_we_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (!ras_q) rcnt <= rcnt + 1'b1;
      case (st)
        S_IDLE: begin
          if (req_valid && !ref_grant) begin
            open_row  <= req_addr[AW-1:COL_W];
            dram_addr <= req_addr[AW-1:COL_W];
            st        <= S_ROW;
          end
        end
        S_ROW: begin
          ras_q <= 1'b0;
          rcnt  <= '0;
          cnt   <= '0;
          st    <= S_ACT;
        end
        S_ACT: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(T_RCD - 1)) st <= S_OPEN;
        end
        S_OPEN: begin
          if (acc) begin
            dram_addr   <= ROW_W'(req_addr[COL_W-1:0]);
            wr_q        <= req_we;
            dram_we_n   <= !req_we;
            dram_dq_oe  <= req_we;
            dram_dq_out <= req_wdata;
            lane_q      <= req_we ? req_be : '1;
            st          <= S_COL;
          end else if (close_row) begin
            ras_q <= 1'b1;
            cnt   <= '0;
            st    <= S_PRE;
          end
        end
        S_COL: begin
          dram_cas_n <= ~lane_q;
          cnt        <= '0;
          st         <= S_CAS;
        end
        S_CAS: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(T_CAS - 1)) begin
            dram_cas_n <= '1;
            dram_we_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            if (!wr_q) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_dq_in;
            end
            cnt <= '0;
            st  <= S_CPRE;
          end
        end
        S_CPRE: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(T_CP - 1)) st <= S_OPEN;
        end
        S_PRE: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(T_RP - 1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int T_RP      = 4,
  parameter int T_RAS_MIN = 6,
  parameter int T_RAS_MAX = 10000,
  parameter int NL        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    ras_n,
  input logic [NL-1:0] cas_n,
  input logic          we_n,
  input logic          dq_oe,
  input logic          req_ready
);
  localparam int RW = $clog2(T_RAS_MAX + 2);
  localparam int HW = $clog2(T_RP + 2);

  logic [RW-1:0] lo_cnt;
  logic [HW-1:0] hi_cnt;
  logic          cas_any;

  assign cas_any = cas_n != '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= HW'(T_RP);
    end else if (!ras_n[0]) begin
      hi_cnt <= '0;
      if (lo_cnt < RW'(T_RAS_MAX)) lo_cnt <= lo_cnt + 1'b1;
    end else begin
      lo_cnt <= '0;
      if (hi_cnt < HW'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_CAS_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n) cas_any |-> ras_n == 2'b00); // R12
  AST_EARLY_WE: assert property (@(posedge clk) disable iff (!rst_n) (cas_any && !$past(cas_any) && !we_n) |-> $past(!we_n)); // R4
  AST_OE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> !we_n); // R4
  AST_READ_BUS: assert property (@(posedge clk) disable iff (!rst_n) (cas_any && we_n) |-> !dq_oe); // R5
  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n[0]) |-> hi_cnt >= HW'(T_RP)); // R7
  AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(ras_n[0]) |-> lo_cnt >= RW'(T_RAS_MIN)); // R8
  AST_RAS_MAX_LOW: assert property (@(posedge clk) disable iff (!rst_n) !ras_n[0] |-> lo_cnt < RW'(T_RAS_MAX)); // R9
  AST_READY_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> ras_n == 2'b00); // R6
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX), .NL(DQ_W / 8)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .dq_oe(dram_dq_oe), .req_ready(req_ready)
);

// File: tb/fpm_dram_ctrl_bench.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_bench;
  localparam int T_RP = 4, T_RCD = 2, T_RAS_MIN = 6, T_RAS_MAX = 60, T_CAS = 3, T_CP = 1;
  localparam int NV = 12;
  // {we, be[3:0], addr[21:0], data[31:0]}
  localparam logic [58:0] VEC [NV] = '{
    {1'b1, 4'hF, 22'h002803, 32'hA1B2C3D4},
    {1'b0, 4'h0, 22'h002803, 32'h0},
    {1'b1, 4'h5, 22'h002804, 32'h11223344},
    {1'b0, 4'h0, 22'h002804, 32'h0},
    {1'b0, 4'h0, 22'h004801, 32'h0},
    {1'b1, 4'h8, 22'h004801, 32'hDEADBEEF},
    {1'b0, 4'h0, 22'h004801, 32'h0},
    {1'b0, 4'h0, 22'h002803, 32'h0},
    {1'b1, 4'h0, 22'h002803, 32'hFFFFFFFF},
    {1'b0, 4'h0, 22'h002803, 32'h0},
    {1'b1, 4'h2, 22'h3FFFFF, 32'h0000AB00},
    {1'b0, 4'h0, 22'h3FFFFF, 32'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ref_grant = 1'b0;
  logic [21:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic req_ready, rd_valid, ref_idle, dram_we_n, dram_dq_oe;
  logic [31:0] rd_data, dram_dq_out;
  logic [31:0] dq_in = '0;
  logic [10:0] dram_addr;
  logic [1:0]  dram_ras_n;
  logic [3:0]  dram_cas_n;

  fpm_dram_ctrl #(.T_RP(T_RP), .T_RCD(T_RCD), .T_RAS_MIN(T_RAS_MIN),
                  .T_RAS_MAX(T_RAS_MAX), .T_CAS(T_CAS), .T_CP(T_CP)) u_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_grant(ref_grant), .ref_idle(ref_idle),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dq_in)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] mem [int];
  logic [31:0] sb  [int];
  logic [21:0] cur_addr = '0;
  int ras_falls = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [21:0] a);
    return {a[9:0], a} ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] mem_rd(input logic [21:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : pat(a);
  endfunction

  function automatic logic [31:0] sb_rd(input logic [21:0] a);
    return sb.exists(int'(a)) ? sb[int'(a)] : pat(a);
  endfunction

  // array model, evaluated between edges
  logic        prev_ras = 1'b1, prev_we = 1'b1;
  logic [3:0]  prev_cas = 4'hF;
  int          lo_len = 0, hi_len = 100;
  int          clo [4] = '{0, 0, 0, 0};
  int          chi [4] = '{100, 100, 100, 100};
  logic [10:0] row_l = '0, col_l = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ras && !dram_ras_n[0]) begin
        chk(hi_len >= T_RP, "R7 precharge", hi_len, T_RP);
        chk(dram_ras_n[1] == 1'b0, "R12 row strobe pair", dram_ras_n, 2'b00);
        chk(dram_addr == cur_addr[21:11], "R2 row address", dram_addr, cur_addr[21:11]);
        row_l = dram_addr;
        ras_falls++;
        lo_len = 0;
      end
      if (!prev_ras && dram_ras_n[0]) begin
        chk(lo_len >= T_RAS_MIN, "R8 min row low", lo_len, T_RAS_MIN);
        chk(lo_len <= T_RAS_MAX, "R9 max row low", lo_len, T_RAS_MAX);
        chk(dram_ras_n[1] == 1'b1, "R12 row strobe pair", dram_ras_n, 2'b11);
        hi_len = 0;
      end
      for (int i = 0; i < 4; i++) begin
        if (prev_cas[i] && !dram_cas_n[i]) begin
          chk(dram_ras_n == 2'b00, "R12 column inside row", dram_ras_n, 2'b00);
          chk(lo_len >= T_RCD + 1, "R2 row-to-column delay", lo_len, T_RCD + 1);
          chk(chi[i] >= T_CP, "R11 column precharge", chi[i], T_CP);
          chk({row_l, dram_addr} == cur_addr, "R3 column address", {row_l, dram_addr}, cur_addr);
          col_l = dram_addr;
          if (!dram_we_n) begin
            logic [31:0] d;
            chk(!prev_we && dram_dq_oe, "R4 early write", {prev_we, dram_dq_oe}, 2'b01);
            d = mem_rd({row_l, dram_addr});
            d[8*i +: 8] = dram_dq_out[8*i +: 8];
            mem[int'({row_l, dram_addr})] = d;
          end
          clo[i] = 0;
        end
        if (!prev_cas[i] && dram_cas_n[i]) begin
          chk(clo[i] >= T_CAS, "R11 column low width", clo[i], T_CAS);
          chi[i] = 0;
        end
        if (!dram_cas_n[i]) clo[i]++; else chi[i]++;
      end
      if (!dram_ras_n[0]) lo_len++; else hi_len++;
      prev_ras = dram_ras_n[0];
      prev_cas = dram_cas_n;
      prev_we  = dram_we_n;
      for (int i = 0; i < 4; i++)
        dq_in[8*i +: 8] = (!dram_cas_n[i] && dram_we_n) ? mem_rd({row_l, col_l})[8*i +: 8] : 8'h00;
    end
  end

  task automatic do_req(input logic we, input logic [21:0] a, input logic [31:0] d, input logic [3:0] be);
    int n;
    cur_addr = a;
    req_we = we; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
    #1;
    n = 0;
    while (!req_ready && n < 500) begin
      @(negedge clk);
      n++;
    end
    @(posedge clk);
    if (we) begin
      logic [31:0] v;
      v = sb_rd(a);
      for (int i = 0; i < 4; i++) if (be[i]) v[8*i +: 8] = d[8*i +: 8];
      sb[int'(a)] = v;
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (we) begin
      repeat (T_CAS + 2) @(negedge clk);
    end else begin
      int lat;
      lat = 1;
      while (!rd_valid && lat < 40) begin
        @(negedge clk);
        lat++;
      end
      chk(lat == T_CAS + 2, "R5 read latency", lat, T_CAS + 2);
      chk(rd_data == sb_rd(a), "R5 R4 read data", rd_data, sb_rd(a));
      @(negedge clk);
      chk(rd_valid == 1'b0, "R5 single pulse", rd_valid, 1'b0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] prev_row;
    repeat (3) @(negedge clk);
    chk(dram_ras_n == 2'b11, "R1 row strobes", dram_ras_n, 2'b11);
    chk(dram_cas_n == 4'hF, "R1 column strobes", dram_cas_n, 4'hF);
    chk(dram_we_n == 1'b1, "R1 write enable", dram_we_n, 1'b1);
    chk(dram_dq_oe == 1'b0, "R1 output enable", dram_dq_oe, 1'b0);
    chk(req_ready == 1'b0, "R1 ready", req_ready, 1'b0);
    chk(rd_valid == 1'b0, "R1 read valid", rd_valid, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    prev_row = 12'hFFF;
    for (int i = 0; i < NV; i++) begin
      logic [58:0] v;
      int f0;
      v = VEC[i];
      f0 = ras_falls;
      do_req(v[58], v[53:32], v[31:0], v[57:54]);
      if ({1'b0, v[53:43]} == prev_row)
        chk(ras_falls == f0, "R6 page hit keeps row", ras_falls, f0);
      else
        chk(ras_falls == f0 + 1, "R7 new row activation", ras_falls, f0 + 1);
      prev_row = {1'b0, v[53:43]};
    end

    // R9: an idle open row closes by itself
    do_req(1'b0, 22'h032005, 32'h0, 4'h0);
    repeat (80) @(negedge clk);
    chk(dram_ras_n == 2'b11, "R9 idle row closed", dram_ras_n, 2'b11);
    chk(ref_idle == 1'b1, "R9 idle after close", ref_idle, 1'b1);

    // R10: refresh grant closes the row and blocks new work
    do_req(1'b0, 22'h032005, 32'h0, 4'h0);
    ref_grant = 1'b1;
    repeat (20) @(negedge clk);
    chk(dram_ras_n == 2'b11, "R10 row closed for refresh", dram_ras_n, 2'b11);
    chk(ref_idle == 1'b1, "R10 idle flag", ref_idle, 1'b1);
    begin
      int f0;
      bit saw;
      f0 = ras_falls;
      saw = 0;
      cur_addr = 22'h032006;
      req_we = 1'b0; req_addr = 22'h032006; req_valid = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (req_ready) saw = 1;
      end
      chk(!saw, "R10 no accept under grant", saw, 0);
      chk(ras_falls == f0, "R10 no activation under grant", ras_falls, f0);
      ref_grant = 1'b0;
      do_req(1'b0, 22'h032006, 32'h0, 4'h0);
      chk(ras_falls == f0 + 1, "R10 resumes after grant", ras_falls, f0 + 1);
    end

    repeat (5) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule